// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block is the digital core of a supply supervisor. It watches two reset causes: a synchronous flag from an external comparator that reports a low supply, and an active-low manual reset pin. The manual pin may be a raw mechanical switch. While either cause is active, the block drives its reset outputs asserted. After the later of the two causes goes away, it keeps reset asserted for a fixed hold time, and then it releases reset.

The manual pin first passes through a multi-stage synchronizer. A debounce counter follows, and it accepts a new pin level only once that level has stayed steady for a set number of cycles. Every timing value is a parameter counted in clock cycles, so the nominal 200 ms hold time can be scaled down for simulation. A watchdog has no direct path into this block. A watchdog timeout causes a reset only when the system wires the watchdog output to the manual pin.

The outputs come as a complementary pair: one active low and one active high. A low-supply condition that is present at power-up holds reset asserted from the first cycle.

Top module: `supv_reset_gen`

## Requirements
- R1: While `lowSupply` is 1, `resetN` is 0 in the same cycle. Asserting `lowSupply` lowers `resetN` without waiting for a clock edge.
- R2: A steady low level on `manRstN` asserts reset (`resetN`=0) right after the (SYNC_STAGES+DEB_CYCLES)-th rising edge following the input change. With the defaults (2, 8) this is the 10th edge.
- R3: Once every cause is inactive, reset stays asserted through the first edge that samples all causes inactive, and through HOLD_CYCLES further edges. `resetN` goes to 1 right after edge HOLD_CYCLES+1. With the default of 20, this is the 21st edge after `lowSupply` falls, and the 31st edge after `manRstN` rises.
- R4: A low pulse on `manRstN` that lasts at most DEB_CYCLES-1 cycles (7 by default) has no effect on `resetN`.
- R5: `resetP` is always the exact inverse of `resetN`.
- R6: A cause that becomes active again during the hold time restarts the hold time from zero. A full HOLD_CYCLES+1 edges are then needed after the cause clears.
- R7: While `rstN` is 0, `resetN` is 0 and `resetP` is 1.
- R8: When both causes overlap, the hold time starts only after the later of the two clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on initialisation, active low |
| lowSupply | input | 1 | Synchronous low-supply flag from the comparator, 1 = supply low |
| manRstN | input | 1 | Asynchronous manual reset pin, 0 = pressed; may bounce |
| resetN | output | 1 | Stretched reset, active low |
| resetP | output | 1 | Stretched reset, active high |

## Verification
Any fault in the hold counter, or any wrong state transition, shows at `resetN` as a release that comes one or more edges too early or too late. The bench therefore samples the output on both sides of the exact release edge. A debounce counter that fails to clear on a bounce would let a short pulse through. About ten cycles after such a pulse, this would show as a spurious reset. A synchronizer depth that is off by one moves the press latency by a single edge, and the sample just before the expected fall catches that.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_ASSERT = 2'd0,
    ST_HOLD   = 2'd1,
    ST_IDLE   = 2'd2
  } supvState_t;

  typedef struct packed {
    logic holdClear;
    logic holdRun;
  } holdStrobe_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 8,
  parameter int unsigned HOLD_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        manRstN,
  input  holdStrobe_t strobes,
  output logic        mrActive,
  output logic        holdDone
);

  localparam int unsigned DEB_W  = (DEB_CYCLES  > 1) ? $clog2(DEB_CYCLES)  : 1;
  localparam int unsigned HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [DEB_W-1:0]  DEB_LAST  = DEB_W'(DEB_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  // synchronizer chain, released level is 1
  logic [SYNC_STAGES-1:0] syncQ;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= manRstN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  logic syncOut;
  assign syncOut = syncQ[SYNC_STAGES-1];

  // debounce: accept a level only after DEB_CYCLES steady cycles
  logic             dbLevel;
  logic [DEB_W-1:0] debCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbLevel <= 1'b1;
      debCnt  <= '0;
    end else if (syncOut == dbLevel) begin
      debCnt  <= '0;
    end else if (debCnt == DEB_LAST) begin
      dbLevel <= syncOut;
      debCnt  <= '0;
    end else begin
      debCnt  <= debCnt + 1'b1;
    end
  end

  assign mrActive = !dbLevel;

  // hold-time counter driven by control strobes
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobes.holdClear) begin
      holdCnt <= '0;
    end else if (strobes.holdRun && !holdDone) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == HOLD_LAST);

  // R4
  debounce_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dbLevel) |-> (dbLevel == $past(syncOut)) && ($past(debCnt) == DEB_LAST));

  // R4
  deb_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    debCnt <= DEB_LAST);

  // R3
  hold_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdDone) |-> $past(strobes.holdRun) && !$past(strobes.holdClear));

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowSupply,
  input  logic        mrActive,
  input  logic        holdDone,
  output holdStrobe_t strobes,
  output logic        resetActive
);

  supvState_t state, stateNext;
  logic       trigger;

  assign trigger = lowSupply | mrActive;

  always_comb begin
    stateNext = state;
    strobes   = '{holdClear: 1'b1, holdRun: 1'b0};
    unique case (state)
      ST_ASSERT: begin
        if (!trigger) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (trigger) begin
          stateNext = ST_ASSERT;
        end else if (holdDone) begin
          stateNext = ST_IDLE;
        end else begin
          strobes = '{holdClear: 1'b0, holdRun: 1'b1};
        end
      end
      ST_IDLE: begin
        if (trigger) stateNext = ST_ASSERT;
      end
      default: stateNext = ST_ASSERT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ASSERT;
    else       state <= stateNext;
  end

  assign resetActive = (state != ST_IDLE) || trigger;

  // R1
  low_supply_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowSupply |=> state == ST_ASSERT);

  // R2
  manual_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    mrActive |=> state == ST_ASSERT);

  // R3
  early_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !holdDone) |=> resetActive);

  // R6
  hold_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && trigger) |=> state == ST_ASSERT);

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 8,
  parameter int unsigned HOLD_CYCLES = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowSupply,
  input  logic manRstN,
  output logic resetN,
  output logic resetP
);

  holdStrobe_t strobes;
  logic        mrActive;
  logic        holdDone;
  logic        resetActive;

  supv_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYCLES (DEB_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .manRstN (manRstN),
    .strobes (strobes),
    .mrActive(mrActive),
    .holdDone(holdDone)
  );

  supv_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .lowSupply  (lowSupply),
    .mrActive   (mrActive),
    .holdDone   (holdDone),
    .strobes    (strobes),
    .resetActive(resetActive)
  );

  assign resetN = !resetActive;
  assign resetP = resetActive;

endmodule

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;

  logic clk = 1'b0;
  logic rstN;
  logic lowSupply;
  logic manRstN;
  logic resetN;
  logic resetP;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  supv_reset_gen u0 (
    .clk(clk), .rstN(rstN), .lowSupply(lowSupply), .manRstN(manRstN),
    .resetN(resetN), .resetP(resetP)
  );

  // vector: {lowSupply, manRstN, edges to wait, expected resetN}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd20, 1'b0},  // R3 one edge before release
    {1'b0, 1'b1, 8'd1,  1'b1},  // R3 released at edge 21
    {1'b0, 1'b1, 8'd5,  1'b1},  // idle stays released
    {1'b1, 1'b1, 8'd0,  1'b0},  // R1 immediate
    {1'b1, 1'b1, 8'd6,  1'b0},  // R1 sustained
    {1'b0, 1'b1, 8'd10, 1'b0},  // partway through hold
    {1'b1, 1'b1, 8'd1,  1'b0},  // R6 trigger again
    {1'b0, 1'b1, 8'd20, 1'b0},  // R6 full hold needed
    {1'b0, 1'b1, 8'd1,  1'b1}   // R6 released
  };

  task automatic chk(input logic expN, input string tag);
    checks++;
    if (resetN !== expN || resetP !== !expN) begin
      errors++;
      $display("FAIL %s: resetN=%b resetP=%b expected resetN=%b resetP=%b (R5 pair)",
               tag, resetN, resetP, expN, !expN);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    lowSupply = 1'b1;
    manRstN = 1'b1;
    #1;
    chk(1'b0, "R7 reset at time zero");
    waitEdges(3);
    chk(1'b0, "R7 reset held");
    rstN = 1'b1;
    waitEdges(4);
    chk(1'b0, "R1 power-on low supply");

    // table walk; inputs change just after a falling edge
    for (int i = 0; i < NV; i++) begin
      lowSupply = VEC[i][10];
      manRstN   = VEC[i][9];
      waitEdges(int'(VEC[i][8:1]));
      chk(VEC[i][0], $sformatf("R3/R1/R6 vector %0d", i));
    end

    // R4: short bounces of 7 cycles are ignored
    for (int b = 0; b < 3; b++) begin
      manRstN = 1'b0;
      waitEdges(7);
      manRstN = 1'b1;
      for (int k = 0; k < 12; k++) begin
        waitEdges(1);
        chk(1'b1, $sformatf("R4 bounce %0d cycle %0d", b, k));
      end
    end

    // R2: press latency of 10 edges
    manRstN = 1'b0;
    waitEdges(9);
    chk(1'b1, "R2 before debounce accept");
    waitEdges(1);
    chk(1'b0, "R2 press accepted");
    waitEdges(30);
    chk(1'b0, "R2 held while pressed");

    // R3: release after 31 edges
    manRstN = 1'b1;
    waitEdges(30);
    chk(1'b0, "R3 manual hold one edge early");
    waitEdges(1);
    chk(1'b1, "R3 manual released");

    // R8: overlapping causes
    manRstN = 1'b0;
    waitEdges(15);
    lowSupply = 1'b1;
    waitEdges(5);
    manRstN = 1'b1;
    waitEdges(45);
    chk(1'b0, "R8 supply still low after manual release");
    lowSupply = 1'b0;
    waitEdges(20);
    chk(1'b0, "R8 hold one edge early");
    waitEdges(1);
    chk(1'b1, "R8 released after later cause");

    // R7: async reset mid-run
    rstN = 1'b0;
    #1;
    chk(1'b0, "R7 async reset asserts");
    waitEdges(2);
    rstN = 1'b1;
    waitEdges(20);
    chk(1'b0, "R7 hold after init");
    waitEdges(1);
    chk(1'b1, "R7 released after init hold");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule